// File: doc/BRIEF.md
# Paged Program-Flow and Stack Unit

This block holds the architectural program counter, an 8-bit page register and a stack pointer for a small byte-oriented processor. Each cycle in which the execute enable is high it takes one decoded instruction: a 4-bit opcode, a one-bit sub-select, an 8-bit operand (a branch target or a register value) and a 3-bit flag index, together with the current flag vector. From these it works out the next program counter and drives a single-port stack memory through read and write strobes, an address and write data. The memory is expected to return read data in the same cycle.

Every jump, call or return target is formed by placing the page register in the upper byte and an 8-bit low byte in the lower byte. A call saves only the low byte of its return address. The upper byte of any far target comes from the page register, which a set-page instruction loads from the upper byte of PC+4. Opcodes that do not affect program flow (0000 to 1010, handled elsewhere) only move the counter forward by one 2-byte instruction.

Top module: `flow_stack_unit`

## Requirements
- R1: After a synchronous reset the PC is 0x0000, the page register is 0x00, the stack pointer is 0x00 (so the first push writes address 0xFF), both stack strobes are low and pop_valid is low.
- R2: While exec_en is low the PC is held, no stack strobe is raised and no state changes.
- R3: Any opcode from 0000 to 1010 advances the PC by 2 and makes no stack access.
- R4: Opcode 1100 branches to {page, operand} when flag_sel is below 5 and the selected flag bit is 1 (index 0 input, 1 overflow, 2 negative, 3 carry, 4 zero, with flags[i] carrying index i). Otherwise the PC advances by 2. Indices 5 to 7 are never taken.
- R5: Opcode 1101 loads the PC with {page, operand}.
- R6: Opcode 1011 with sub_sel 0 (push) decrements the stack pointer, writes the operand at the new pointer value in the same cycle, and advances the PC by 2.
- R7: Opcode 1011 with sub_sel 1 (pop) reads at the current stack pointer and then increments it. In the following cycle pop_data holds the byte that was read and pop_valid is high for exactly one cycle. The PC advances by 2.
- R8: Opcode 1110 (call) pushes the low byte of PC+2 in the same way as R6 and loads the PC with {page, operand}.
- R9: Opcode 1111 with sub_sel 0 (set-page) loads the page register with the upper byte of PC+4 and advances the PC by 2. Later targets use the new page.
- R10: Opcode 1111 with sub_sel 1 (return) reads at the stack pointer, increments it, and loads the PC with {page, read byte}. pop_valid stays low.
- R11: The stack pointer wraps modulo 256 in both directions.
- R12: The read and write strobes are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| exec_en | input | 1 | One instruction executes in this cycle |
| op_code | input | 4 | Decoded opcode |
| sub_sel | input | 1 | Chooses between the two operations that share opcode 1011 or 1111 |
| operand | input | 8 | Target low byte or register value to push |
| flag_sel | input | 3 | Flag index for a conditional branch |
| flags | input | 5 | Flag vector, bit i is flag index i |
| stk_rdata | input | 8 | Stack memory read data, valid in the same cycle |
| stk_rd_en | output | 1 | Stack read strobe |
| stk_wr_en | output | 1 | Stack write strobe |
| stk_addr | output | 8 | Stack memory address |
| stk_wdata | output | 8 | Stack write data |
| pop_data | output | 8 | Last byte popped into a register |
| pop_valid | output | 1 | pop_data was updated in the previous cycle |
| pc | output | 16 | Program counter after the last executed step |

## Verification
The hardest case to reach from the ports is a return whose target shows both a page loaded earlier by set-page and a low byte saved earlier by a call. The page only moves when set-page runs at a PC whose low byte is 0xFC or higher, so the stimulus first jumps to 0x00FC and issues set-page there, which carries into page 0x01. It then calls and returns while the stack is in use. Stack-pointer wrap is reached by pushing from the reset pointer and by popping past 0xFF. Because the bench keeps its own model of the stack contents, every popped byte and every return target can be predicted.

// File: rtl/flow_pkg.sv
package flow_pkg;

    localparam logic [3:0] OPC_STACK = 4'b1011;
    localparam logic [3:0] OPC_BFLAG = 4'b1100;
    localparam logic [3:0] OPC_JUMP  = 4'b1101;
    localparam logic [3:0] OPC_CALL  = 4'b1110;
    localparam logic [3:0] OPC_PAGE  = 4'b1111;

    localparam int unsigned FLAG_COUNT = 5;

    typedef enum logic [1:0] {
        STK_IDLE = 2'd0,
        STK_PUSH = 2'd1,
        STK_POP  = 2'd2
    } stk_act_e;

endpackage

// File: rtl/flow_flag_pick.sv
module flow_flag_pick #(
    parameter int unsigned NFLAG = 5,
    parameter int unsigned SELW  = 3
) (
    input  logic [NFLAG-1:0] flag_vec,
    input  logic [SELW-1:0]  sel,
    output logic             hit
);
    logic [(1<<SELW)-1:0] padded;

    generate
        for (genvar i = 0; i < (1 << SELW); i++) begin : g_pad
            if (i < NFLAG) begin : g_real
                assign padded[i] = flag_vec[i];
            end else begin : g_none
                assign padded[i] = 1'b0;
            end
        end
    endgenerate

    always_comb begin
        hit = padded[sel];
    end
endmodule

// File: rtl/flow_addr_gen.sv
module flow_addr_gen #(
    parameter int unsigned DW = 8
) (
    input  logic [2*DW-1:0] pc_cur,
    input  logic [DW-1:0]   page_cur,
    input  logic [DW-1:0]   low_imm,
    input  logic [DW-1:0]   low_stk,
    output logic [2*DW-1:0] pc_step,
    output logic [DW-1:0]   step_lo,
    output logic [DW-1:0]   far_hi,
    output logic [2*DW-1:0] tgt_imm,
    output logic [2*DW-1:0] tgt_stk
);
    localparam int unsigned PCW = 2 * DW;
    localparam logic [DW-1:0] CARRY_EDGE = DW'((1 << DW) - 5);

    logic [DW-1:0] pc_lo;
    logic [DW-1:0] pc_hi;
    logic          far_carry;

    always_comb begin
        pc_lo     = pc_cur[DW-1:0];
        pc_hi     = pc_cur[PCW-1:DW];
        pc_step   = pc_cur + PCW'(2);
        step_lo   = pc_step[DW-1:0];
        far_carry = (pc_lo > CARRY_EDGE);
        far_hi    = pc_hi + DW'(far_carry);
        tgt_imm   = {page_cur, low_imm};
        tgt_stk   = {page_cur, low_stk};
    end
endmodule

// File: rtl/flow_stack_ctrl.sv
module flow_stack_ctrl
    import flow_pkg::*;
#(
    parameter int unsigned AW      = 8,
    parameter int unsigned DW      = 8,
    parameter logic [AW-1:0] SP_INIT = '0
) (
    input  logic          clk,
    input  logic          rst,
    input  stk_act_e      act,
    input  logic [DW-1:0] push_val,
    output logic          rd_en,
    output logic          wr_en,
    output logic [AW-1:0] addr,
    output logic [DW-1:0] wdata
);
    logic [AW-1:0] sp_d;
    logic [AW-1:0] sp_q;

    always_comb begin
        sp_d  = sp_q;
        rd_en = 1'b0;
        wr_en = 1'b0;
        addr  = sp_q;
        wdata = push_val;
        if (!rst) begin
            unique case (act)
                STK_PUSH: begin
                    sp_d  = sp_q - AW'(1);
                    addr  = sp_d;
                    wr_en = 1'b1;
                end
                STK_POP: begin
                    rd_en = 1'b1;
                    addr  = sp_q;
                    sp_d  = sp_q + AW'(1);
                end
                default: begin
                    sp_d = sp_q;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) sp_q <= SP_INIT;
        else     sp_q <= sp_d;
    end

    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(rd_en && wr_en)); // R12
    AST_PUSH_LANDS: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (sp_q == $past(addr))); // R6
    AST_POP_RISES: assert property (@(posedge clk) disable iff (rst)
        rd_en |=> (sp_q == AW'($past(addr) + AW'(1)))); // R7
endmodule

// File: rtl/flow_stack_unit.sv
module flow_stack_unit
    import flow_pkg::*;
#(
    parameter int unsigned DW      = 8,
    parameter int unsigned AW      = 8,
    parameter int unsigned SELW    = 3,
    parameter logic [AW-1:0] SP_INIT = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             exec_en,
    input  logic [3:0]       op_code,
    input  logic             sub_sel,
    input  logic [DW-1:0]    operand,
    input  logic [SELW-1:0]  flag_sel,
    input  logic [FLAG_COUNT-1:0] flags,
    input  logic [DW-1:0]    stk_rdata,
    output logic             stk_rd_en,
    output logic             stk_wr_en,
    output logic [AW-1:0]    stk_addr,
    output logic [DW-1:0]    stk_wdata,
    output logic [DW-1:0]    pop_data,
    output logic             pop_valid,
    output logic [2*DW-1:0]  pc
);
    localparam int unsigned PCW = 2 * DW;

    typedef struct packed {
        logic [PCW-1:0] pc;
        logic [DW-1:0]  page;
        logic [DW-1:0]  pop_data;
        logic           pop_valid;
    } flow_state_t;

    flow_state_t st_d;
    flow_state_t st_q;

    logic [PCW-1:0] pc_step;
    logic [DW-1:0]  step_lo;
    logic [DW-1:0]  far_hi;
    logic [PCW-1:0] tgt_imm;
    logic [PCW-1:0] tgt_stk;
    logic           flag_hit;
    stk_act_e       act_d;
    logic [DW-1:0]  push_val_d;

    flow_flag_pick #(.NFLAG(FLAG_COUNT), .SELW(SELW)) u_pick (
        .flag_vec (flags),
        .sel      (flag_sel),
        .hit      (flag_hit)
    );

    flow_addr_gen #(.DW(DW)) u_addr (
        .pc_cur   (st_q.pc),
        .page_cur (st_q.page),
        .low_imm  (operand),
        .low_stk  (stk_rdata),
        .pc_step  (pc_step),
        .step_lo  (step_lo),
        .far_hi   (far_hi),
        .tgt_imm  (tgt_imm),
        .tgt_stk  (tgt_stk)
    );

    // stack action decode
    always_comb begin
        act_d      = STK_IDLE;
        push_val_d = operand;
        if (exec_en) begin
            unique case (op_code)
                OPC_STACK: act_d = sub_sel ? STK_POP : STK_PUSH;
                OPC_CALL: begin
                    act_d      = STK_PUSH;
                    push_val_d = step_lo;
                end
                OPC_PAGE:  act_d = sub_sel ? STK_POP : STK_IDLE;
                default:   act_d = STK_IDLE;
            endcase
        end
    end

    flow_stack_ctrl #(.AW(AW), .DW(DW), .SP_INIT(SP_INIT)) u_stack (
        .clk      (clk),
        .rst      (rst),
        .act      (act_d),
        .push_val (push_val_d),
        .rd_en    (stk_rd_en),
        .wr_en    (stk_wr_en),
        .addr     (stk_addr),
        .wdata    (stk_wdata)
    );

    // next-state process
    always_comb begin
        st_d           = st_q;
        st_d.pop_valid = 1'b0;
        if (exec_en) begin
            st_d.pc = pc_step;
            unique case (op_code)
                OPC_BFLAG: begin
                    if (flag_hit) st_d.pc = tgt_imm;
                end
                OPC_JUMP, OPC_CALL: begin
                    st_d.pc = tgt_imm;
                end
                OPC_PAGE: begin
                    if (sub_sel) st_d.pc   = tgt_stk;
                    else         st_d.page = far_hi;
                end
                OPC_STACK: begin
                    if (sub_sel) begin
                        st_d.pop_data  = stk_rdata;
                        st_d.pop_valid = 1'b1;
                    end
                end
                default: begin
                    st_d.pc = pc_step;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign pc        = st_q.pc;
    assign pop_data  = st_q.pop_data;
    assign pop_valid = st_q.pop_valid;

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !exec_en |=> $stable(st_q.pc)); // R2
    AST_ALU_STEP: assert property (@(posedge clk) disable iff (rst)
        (exec_en && op_code < OPC_STACK) |=> (st_q.pc == PCW'($past(st_q.pc) + PCW'(2)))); // R3
    AST_HIGH_INDEX: assert property (@(posedge clk) disable iff (rst)
        (exec_en && op_code == OPC_BFLAG && flag_sel >= SELW'(FLAG_COUNT))
        |=> (st_q.pc == PCW'($past(st_q.pc) + PCW'(2)))); // R4
    AST_FAR_TARGET: assert property (@(posedge clk) disable iff (rst)
        (exec_en && (op_code == OPC_JUMP || op_code == OPC_CALL))
        |=> (st_q.pc == {$past(st_q.page), $past(operand)})); // R5
    AST_POP_SOURCE: assert property (@(posedge clk) disable iff (rst)
        pop_valid |-> $past(stk_rd_en)); // R7
    AST_CALL_WRITES: assert property (@(posedge clk) disable iff (rst)
        (exec_en && op_code == OPC_CALL) |-> (stk_wr_en && !stk_rd_en)); // R8
endmodule

// File: tb/sim_flow_stack_unit.sv
module sim_flow_stack_unit;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        exec_en = 1'b0;
    logic [3:0]  op_code = '0;
    logic        sub_sel = 1'b0;
    logic [7:0]  operand = '0;
    logic [2:0]  flag_sel = '0;
    logic [4:0]  flags = '0;
    logic [7:0]  stk_rdata;
    logic        stk_rd_en, stk_wr_en;
    logic [7:0]  stk_addr, stk_wdata, pop_data;
    logic        pop_valid;
    logic [15:0] pc;

    always #2 clk = ~clk;

    flow_stack_unit u0 (
        .clk(clk), .rst(rst), .exec_en(exec_en), .op_code(op_code),
        .sub_sel(sub_sel), .operand(operand), .flag_sel(flag_sel),
        .flags(flags), .stk_rdata(stk_rdata), .stk_rd_en(stk_rd_en),
        .stk_wr_en(stk_wr_en), .stk_addr(stk_addr), .stk_wdata(stk_wdata),
        .pop_data(pop_data), .pop_valid(pop_valid), .pc(pc)
    );

    logic [7:0] ram [256];
    assign stk_rdata = ram[stk_addr];
    always @(posedge clk) if (stk_wr_en) ram[stk_addr] <= stk_wdata;

    typedef struct {
        string       req;
        logic        rd, wr;
        logic [7:0]  addr, wdata;
        logic [15:0] pc;
        logic        popv;
        logic [7:0]  popd;
    } exp_t;

    exp_t exp_q[$];
    int   total = 0;
    int   bad = 0;
    bit   done = 0;

    logic [15:0] m_pc = '0;
    logic [7:0]  m_page = '0;
    logic [7:0]  m_sp = '0;
    logic [7:0]  m_mem [256];

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] expv);
        total++;
        if (act !== expv) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    task automatic step(string req, logic en, logic [3:0] op, logic sb,
                        logic [7:0] v, logic [2:0] fs, logic [4:0] fl);
        exp_t e;
        logic [15:0] npc;
        logic [15:0] tmp;
        @(negedge clk);
        exec_en = en; op_code = op; sub_sel = sb; operand = v;
        flag_sel = fs; flags = fl;
        e.req = req; e.rd = 0; e.wr = 0; e.addr = 0; e.wdata = 0;
        e.popv = 0; e.popd = 0;
        npc = m_pc + 16'd2;
        if (!en) npc = m_pc;
        else begin
            case (op)
                4'b1011: if (!sb) begin
                        m_sp = m_sp - 8'd1; e.wr = 1; e.addr = m_sp; e.wdata = v;
                        m_mem[m_sp] = v;
                    end else begin
                        e.rd = 1; e.addr = m_sp; e.popv = 1; e.popd = m_mem[m_sp];
                        m_sp = m_sp + 8'd1;
                    end
                4'b1100: if (fs < 3'd5 && fl[fs]) npc = {m_page, v};
                4'b1101: npc = {m_page, v};
                4'b1110: begin
                    tmp = m_pc + 16'd2;
                    m_sp = m_sp - 8'd1; e.wr = 1; e.addr = m_sp; e.wdata = tmp[7:0];
                    m_mem[m_sp] = tmp[7:0];
                    npc = {m_page, v};
                end
                4'b1111: if (!sb) begin
                        tmp = m_pc + 16'd4; m_page = tmp[15:8];
                    end else begin
                        e.rd = 1; e.addr = m_sp; npc = {m_page, m_mem[m_sp]};
                        m_sp = m_sp + 8'd1;
                    end
                default: npc = m_pc + 16'd2;
            endcase
        end
        m_pc = npc;
        e.pc = npc;
        exp_q.push_back(e);
    endtask

    // monitor: strobes of the current step, then its result one cycle later
    initial begin
        exp_t pend;
        bit   have = 0;
        forever begin
            @(negedge clk);
            #1;
            if (have) begin
                chk(pend.req, "pc", 32'(pc), 32'(pend.pc));
                chk(pend.req, "pop_valid", 32'(pop_valid), 32'(pend.popv));
                if (pend.popv) chk(pend.req, "pop_data", 32'(pop_data), 32'(pend.popd));
                have = 0;
            end
            if (exp_q.size() > 0) begin
                pend = exp_q.pop_front();
                have = 1;
                chk(pend.req, "rd_en", 32'(stk_rd_en), 32'(pend.rd));
                chk(pend.req, "wr_en", 32'(stk_wr_en), 32'(pend.wr));
                if (pend.rd || pend.wr) chk(pend.req, "addr", 32'(stk_addr), 32'(pend.addr));
                if (pend.wr) chk(pend.req, "wdata", 32'(stk_wdata), 32'(pend.wdata));
                // R12: strobes exclusive
                chk(pend.req, "R12 strobes", 32'(stk_rd_en & stk_wr_en), 32'd0);
            end
        end
    end

    initial begin
        #400000;
        if (!done) begin
            done = 1;
            bad++; total++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 256; i++) begin
            ram[i]   = 8'(i) ^ 8'h5A;
            m_mem[i] = 8'(i) ^ 8'h5A;
        end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        // R1 reset state
        chk("R1", "pc", 32'(pc), 32'h0);
        chk("R1", "pop_valid", 32'(pop_valid), 32'h0);
        chk("R1", "strobes", 32'({stk_rd_en, stk_wr_en}), 32'h0);
        // R2 idle
        step("R2", 0, 4'b1101, 0, 8'h77, 0, 0);
        step("R2", 0, 4'b1011, 0, 8'h11, 0, 0);
        // R3 non-flow opcodes
        step("R3", 1, 4'b0000, 0, 8'h12, 0, 0);
        step("R3", 1, 4'b0101, 1, 8'h34, 0, 0);
        step("R3", 1, 4'b1010, 0, 8'h56, 0, 0);
        // R5 jump
        step("R5", 1, 4'b1101, 0, 8'h40, 0, 0);
        // R6 push, R1 first push lands at 0xFF, R11 wrap down
        step("R6", 1, 4'b1011, 0, 8'hA5, 0, 0);
        step("R6", 1, 4'b1011, 0, 8'h3C, 0, 0);
        // R7 pops
        step("R7", 1, 4'b1011, 1, 8'h00, 0, 0);
        step("R7", 1, 4'b1011, 1, 8'h00, 0, 0);
        // R11 pop at 0x00 then push back, pop across 0xFF
        step("R11", 1, 4'b1011, 1, 8'h00, 0, 0);
        step("R11", 1, 4'b1011, 0, 8'hC3, 0, 0);
        step("R11", 1, 4'b1011, 0, 8'h9E, 0, 0);
        step("R11", 1, 4'b1011, 1, 8'h00, 0, 0);
        step("R11", 1, 4'b1011, 1, 8'h00, 0, 0);
        // R4 branch flag selection
        step("R4", 1, 4'b1100, 0, 8'h80, 3'd2, 5'b10100);
        step("R4", 1, 4'b1100, 0, 8'h90, 3'd3, 5'b10100);
        step("R4", 1, 4'b1100, 0, 8'hA0, 3'd4, 5'b10100);
        step("R4", 1, 4'b1100, 0, 8'hB0, 3'd0, 5'b10100);
        step("R4", 1, 4'b1100, 0, 8'hC0, 3'd6, 5'b11111);
        step("R4", 1, 4'b1100, 0, 8'hD0, 3'd1, 5'b00010);
        step("R4", 1, 4'b1100, 0, 8'hE0, 3'd7, 5'b11111);
        // R9 set-page with and without carry into the page
        step("R9", 1, 4'b1111, 0, 8'h00, 0, 0);
        step("R9", 1, 4'b1101, 0, 8'hFC, 0, 0);
        step("R9", 1, 4'b1111, 0, 8'h00, 0, 0);
        step("R9", 1, 4'b1101, 0, 8'h10, 0, 0);
        // R8 call, R10 return
        step("R8", 1, 4'b1110, 0, 8'h30, 0, 0);
        step("R8", 1, 4'b1110, 1, 8'h50, 0, 0);
        step("R10", 1, 4'b1111, 1, 8'h00, 0, 0);
        step("R10", 1, 4'b1111, 1, 8'h00, 0, 0);
        step("R7", 1, 4'b1011, 1, 8'h00, 0, 0);
        step("R2", 0, 4'b1111, 1, 8'h00, 0, 0);
        repeat (3) @(negedge clk);
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule